// File: doc/BRIEF.md
# PHY Management Register File

This block is a register-level model of the management registers of a Fast Ethernet PHY. A host drives a PHY address and a register index on the select inputs. It reads the selected register combinationally on `rd_data` and writes it by pulsing `wr_en` with `wr_data` for one clock. Only the register behaviour seen by the host is modelled. Serial management timing and real auto-negotiation are outside this block.

The block stores the control and advertisement registers. The status and link-partner registers are built from a fixed capability set and a registered copy of the `link_up` input. The two identifier registers return parameter values. A control write with the reset bit set restores the default register contents instead of storing the written word. Accesses that carry a PHY address other than `PHY_ADDR` read all ones and change nothing.

Top module: `phy_mgmt_regs`

## Requirements
- R1: A read whose `sel_phy` differs from `PHY_ADDR` returns 16'hFFFF for every register index.
- R2: A write whose `sel_phy` differs from `PHY_ADDR` leaves every register unchanged.
- R3: After `rst_n` is low, the control register (index 0) reads 16'h3100, which is 100 Mb/s at bit 13, auto-negotiation enabled at bit 12 and full duplex at bit 8. The advertisement register (index 4) reads 16'h01E1, which is 100-full at bit 8, 100-half at bit 7, 10-full at bit 6, 10-half at bit 5 and selector at bit 0.
- R4: The status register (index 1) reads 16'h7848 while the link is down. While the link is up it reads 16'h786C, which adds link status at bit 2 and auto-negotiation complete at bit 5.
- R5: The partner-ability register (index 5) reads 16'h0080 while the link is down and 16'h01E1 while the link is up.
- R6: A change on `link_up` appears in registers 1 and 5 after the first rising clock edge that follows it.
- R7: A control write with bit 15 set restores the control and advertisement registers to their R3 values. A control write with bit 15 clear stores the word exactly as written.
- R8: A write to index 4 stores the word exactly as written.
- R9: Writes to any index other than 0 and 4 are ignored. This includes the status, identifier, partner and expansion registers.
- R10: Index 2 reads `ID_HI` and index 3 reads `ID_LO`.
- R11: Reads of index 6 and every index above it return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_up | input | 1 | Link state, 1 = up |
| sel_phy | input | ADDR_W | PHY address of the access |
| sel_reg | input | REG_W | Register index of the access |
| wr_en | input | 1 | One-cycle write strobe |
| wr_data | input | 16 | Write word |
| rd_data | output | 16 | Read word for the current selection |

## Verification
The assertions assume that `sel_phy`, `sel_reg`, `wr_en` and `wr_data` only change away from the rising edge. They also assume that a write lasts exactly one clock, so each sampled strobe is one intended write. The bench changes every input on the falling edge and holds `wr_en` for a single cycle. It sweeps all 32 indices under both link states and with every foreign PHY address.

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs #(
  parameter int ADDR_W = 5,
  parameter int REG_W = 5,
  parameter logic [ADDR_W-1:0] PHY_ADDR = 'd1,
  parameter logic [15:0] ID_HI = 16'h02A5,
  parameter logic [15:0] ID_LO = 16'h5C31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_up,
  input  logic [ADDR_W-1:0] sel_phy,
  input  logic [REG_W-1:0]  sel_reg,
  input  logic              wr_en,
  input  logic [15:0]       wr_data,
  output logic [15:0]       rd_data
);
  localparam logic [15:0] CTRL_DEF  = 16'h3100;
  localparam logic [15:0] ADV_DEF   = 16'h01E1;
  localparam logic [15:0] STAT_BASE = 16'h7848;
  localparam logic [15:0] STAT_LINK = 16'h0024;
  localparam logic [15:0] LP_UP     = 16'h01E1;
  localparam logic [15:0] LP_DOWN   = 16'h0080;
  localparam logic [REG_W-1:0] IX_CTRL = 'd0;
  localparam logic [REG_W-1:0] IX_STAT = 'd1;
  localparam logic [REG_W-1:0] IX_ID1  = 'd2;
  localparam logic [REG_W-1:0] IX_ID2  = 'd3;
  localparam logic [REG_W-1:0] IX_ADV  = 'd4;
  localparam logic [REG_W-1:0] IX_LP   = 'd5;

  logic [15:0] ctrl_q, adv_q;
  logic        link_q;

  wire hit    = (sel_phy == PHY_ADDR);
  wire wr_hit = wr_en && hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_DEF;
      adv_q  <= ADV_DEF;
      link_q <= 1'b0;
    end else begin
      link_q <= link_up;
      if (wr_hit && sel_reg == IX_CTRL) begin
        if (wr_data[15]) begin
          ctrl_q <= CTRL_DEF;
          adv_q  <= ADV_DEF;
        end else begin
          ctrl_q <= wr_data;
        end
      end
      if (wr_hit && sel_reg == IX_ADV) adv_q <= wr_data;
    end
  end

  wire [15:0] stat_w = link_q ? (STAT_BASE | STAT_LINK) : STAT_BASE;
  wire [15:0] lp_w   = link_q ? LP_UP : LP_DOWN;

  always_comb begin
    if (!hit) rd_data = 16'hFFFF;
    else begin
      case (sel_reg)
        IX_CTRL: rd_data = ctrl_q;
        IX_STAT: rd_data = stat_w;
        IX_ID1:  rd_data = ID_HI;
        IX_ID2:  rd_data = ID_LO;
        IX_ADV:  rd_data = adv_q;
        IX_LP:   rd_data = lp_w;
        default: rd_data = 16'h0000;
      endcase
    end
  end
endmodule

// File: rtl/phy_mgmt_regs_chk.sv
module phy_mgmt_regs_chk #(
  parameter int ADDR_W = 5,
  parameter int REG_W = 5,
  parameter logic [ADDR_W-1:0] PHY_ADDR = 'd1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] sel_phy,
  input logic [REG_W-1:0]  sel_reg,
  input logic              wr_en,
  input logic [15:0]       wr_data,
  input logic [15:0]       rd_data,
  input logic [15:0]       ctrl_q,
  input logic [15:0]       adv_q
);
  a_r1_foreign_read: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_phy != PHY_ADDR) |-> rd_data == 16'hFFFF);

  a_r2_foreign_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel_phy != PHY_ADDR) |=> ($stable(ctrl_q) && $stable(adv_q)));

  a_r7_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel_phy == PHY_ADDR && sel_reg == '0 && wr_data[15])
      |=> (ctrl_q == 16'h3100 && adv_q == 16'h01E1));

  a_r7_ctrl_store: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel_phy == PHY_ADDR && sel_reg == '0 && !wr_data[15])
      |=> ctrl_q == $past(wr_data));

  a_r8_adv_store: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel_phy == PHY_ADDR && sel_reg == 'd4) |=> adv_q == $past(wr_data));

  a_r9_ignored_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel_reg != '0 && sel_reg != 'd4) |=> ($stable(ctrl_q) && $stable(adv_q)));

  a_r4_link_bits_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_phy == PHY_ADDR && sel_reg == 'd1) |-> rd_data[2] == rd_data[5]);

  a_r5_partner_forms: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_phy == PHY_ADDR && sel_reg == 'd5) |-> (rd_data == 16'h0080 || rd_data == 16'h01E1));
endmodule

bind phy_mgmt_regs phy_mgmt_regs_chk #(.ADDR_W(ADDR_W), .REG_W(REG_W), .PHY_ADDR(PHY_ADDR)) chk (
  .clk(clk), .rst_n(rst_n), .sel_phy(sel_phy), .sel_reg(sel_reg), .wr_en(wr_en),
  .wr_data(wr_data), .rd_data(rd_data), .ctrl_q(ctrl_q), .adv_q(adv_q));

// File: tb/phy_mgmt_regs_test.sv
module phy_mgmt_regs_test;
  localparam logic [4:0]  PA  = 5'd1;
  localparam logic [15:0] IDH = 16'h02A5;
  localparam logic [15:0] IDL = 16'h5C31;

  logic clk = 0, rst_n = 0, link_up = 0, wr_en = 0;
  logic [4:0] sel_phy = 0, sel_reg = 0;
  logic [15:0] wr_data = 0, rd_data;
  int checks = 0, failures = 0;
  bit done = 0;
  logic [15:0] m_ctrl, m_adv;
  logic m_link;

  always #10 clk = ~clk;

  phy_mgmt_regs #(.PHY_ADDR(PA), .ID_HI(IDH), .ID_LO(IDL)) uut (
    .clk(clk), .rst_n(rst_n), .link_up(link_up), .sel_phy(sel_phy), .sel_reg(sel_reg),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data));

  function automatic logic [15:0] expect_rd(input logic [4:0] p, input logic [4:0] r);
    if (p != PA) return 16'hFFFF;
    case (r)
      5'd0: return m_ctrl;
      5'd1: return m_link ? 16'h786C : 16'h7848;
      5'd2: return IDH;
      5'd3: return IDL;
      5'd4: return m_adv;
      5'd5: return m_link ? 16'h01E1 : 16'h0080;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic check_rd(input string req, input logic [4:0] p, input logic [4:0] r);
    logic [15:0] e;
    @(negedge clk);
    sel_phy = p; sel_reg = r;
    #1;
    e = expect_rd(p, r);
    checks++;
    if (rd_data !== e) begin
      failures++;
      $display("FAIL %s phy=%0d reg=%0d actual=%h expected=%h", req, p, r, rd_data, e);
    end
  endtask

  task automatic do_wr(input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
    @(negedge clk);
    sel_phy = p; sel_reg = r; wr_data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
    if (p == PA && r == 5'd0) begin
      if (d[15]) begin m_ctrl = 16'h3100; m_adv = 16'h01E1; end
      else m_ctrl = d;
    end
    if (p == PA && r == 5'd4) m_adv = d;
  endtask

  task automatic set_link(input logic v);
    @(negedge clk);
    link_up = v;
    @(negedge clk);
    m_link = v;
  endtask

  initial begin
    m_ctrl = 16'h3100; m_adv = 16'h01E1; m_link = 0;
    // R3 reset state, sampled while reset is still held
    repeat (2) @(negedge clk);
    check_rd("R3", PA, 5'd0);
    check_rd("R3", PA, 5'd4);
    check_rd("R4", PA, 5'd1);
    check_rd("R5", PA, 5'd5);
    @(negedge clk) rst_n = 1;

    // R4 R5 R10 R11: full index sweep in both link states
    for (int l = 0; l < 2; l++) begin
      set_link(l[0]);
      for (int r = 0; r < 32; r++)
        check_rd(r < 2 ? "R4" : r < 4 ? "R10" : r == 5 ? "R5" : r > 5 ? "R11" : "R3", PA, r[4:0]);
    end

    // R6: status and partner updated one edge after a link change
    @(negedge clk) link_up = 0;
    @(negedge clk) m_link = 0;
    check_rd("R6", PA, 5'd1);
    check_rd("R6", PA, 5'd5);
    @(negedge clk) link_up = 1;
    @(negedge clk) m_link = 1;
    check_rd("R6", PA, 5'd1);
    check_rd("R6", PA, 5'd5);

    // R1: every foreign address reads all ones
    for (int p = 0; p < 32; p++)
      if (p[4:0] != PA) begin
        check_rd("R1", p[4:0], 5'd0);
        check_rd("R1", p[4:0], 5'd1);
      end

    // R2: foreign writes to control and advertisement have no effect
    for (int p = 0; p < 32; p++)
      if (p[4:0] != PA) begin
        do_wr(p[4:0], 5'd0, 16'h0A5A ^ p[15:0]);
        do_wr(p[4:0], 5'd4, 16'h8000);
      end
    check_rd("R2", PA, 5'd0);
    check_rd("R2", PA, 5'd4);

    // R8: advertisement stored as written
    do_wr(PA, 5'd4, 16'h0061);
    check_rd("R8", PA, 5'd4);
    do_wr(PA, 5'd4, 16'hFFFF);
    check_rd("R8", PA, 5'd4);

    // R7: plain control writes stored verbatim
    do_wr(PA, 5'd0, 16'h0000);
    check_rd("R7", PA, 5'd0);
    do_wr(PA, 5'd0, 16'h7FFF);
    check_rd("R7", PA, 5'd0);

    // R9: writes to every other index ignored
    for (int r = 0; r < 32; r++)
      if (r != 0 && r != 4) begin
        do_wr(PA, r[4:0], 16'h5A5A ^ r[15:0]);
        check_rd("R9", PA, 5'd0);
        check_rd("R9", PA, 5'd4);
        check_rd("R9", PA, r[4:0]);
      end

    // R7: soft reset restores control and advertisement
    do_wr(PA, 5'd0, 16'h8000);
    check_rd("R7", PA, 5'd0);
    check_rd("R7", PA, 5'd4);
    check_rd("R7", PA, 5'd1);
    do_wr(PA, 5'd4, 16'h0021);
    do_wr(PA, 5'd0, 16'h0400);
    do_wr(PA, 5'd0, 16'hFFFF);
    check_rd("R7", PA, 5'd0);
    check_rd("R7", PA, 5'd4);

    // R4 R5 after soft reset with link down
    set_link(1'b0);
    check_rd("R4", PA, 5'd1);
    check_rd("R5", PA, 5'd5);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule